// File: doc/BRIEF.md
# Vertical Acquisition Timer

This block runs on the input side of a field-rate converter and is clocked by the pixel clock. A line counter advances only on a one-cycle line-rate pulse. It restarts on each rising edge of the incoming vertical sync. At that same edge the count reached so far is kept as the length of the field just ended. The display-rate logic reads that value, and the sync-to-line offset, to correct its own vertical timing.

The offset is measured in pixel clocks, from the cycle of the sync edge to the first line pulse that follows it. The block also drives three outputs from the line count. The memory write-reset pulse is high while the count is zero. The write window is open over a span of lines set by a start register and a stop register. A field identification bit flips on every incoming field.

Top module: `vacq_timing`

## Requirements
- R1: After reset, line_cnt, field_len, sync_offset and field_id are 0, wr_reset is 1 and wr_window is 0 whenever win_start is above 0.
- R2: line_cnt rises by exactly one in the cycle after a line_pulse that does not fall on a sync edge, and it holds in every cycle with no line_pulse and no sync edge.
- R3: On a rising edge of vsync_in, field_len takes the value line_cnt had in that cycle and line_cnt becomes 0 in the next cycle. A line_pulse in the same cycle as the edge is not counted.
- R4: line_cnt saturates at 2^LINE_W-1: further line pulses leave it there, and field_len then reports 2^LINE_W-1.
- R5: sync_offset gives the number of clock cycles from the sync-edge cycle to the first line_pulse cycle after it. It is 0 when the two fall in the same cycle. Later line pulses in the same field leave it unchanged.
- R6: wr_reset is 1 exactly while line_cnt is 0. It rises only in the cycle after a sync edge.
- R7: wr_window is 1 exactly when win_start <= line_cnt < win_stop. It is never 1 when win_start >= win_stop.
- R8: field_id inverts once on each rising sync edge and is otherwise stable.
- R9: A sync held high for many cycles is one edge. Line pulses during that time are counted normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vsync_in | input | 1 | Incoming vertical sync, level; its rising edge is used |
| line_pulse | input | 1 | One-cycle line-rate pulse |
| win_start | input | LINE_W | First line of the write window |
| win_stop | input | LINE_W | First line after the write window |
| line_cnt | output | LINE_W | Current line number in the field |
| field_len | output | LINE_W | Line count captured at the last sync edge |
| sync_offset | output | OFF_W | Clocks from the sync edge to the next line pulse |
| field_id | output | 1 | Field identification toggle |
| wr_reset | output | 1 | Vertical write-reset pulse |
| wr_window | output | 1 | Vertical write window enable |

## Verification
A sync edge and a line pulse can arrive in the same clock cycle. In that cycle the length capture, the counter restart and the offset latch all compete. The bench drives both inputs high at the same negative edge in one table vector. It then expects line_cnt to be 0, sync_offset to be 0 and the following field length to be one short of the pulses sent. A bound property also checks that any such coincidence leaves the offset at zero.

// File: rtl/vacq_pkg.sv
package vacq_pkg;
  localparam int unsigned WIDE_W = 16;
  typedef logic [WIDE_W-1:0] wide_t;

  // Window is half-open: open from lo up to, not including, hi.
  function automatic logic in_window(wide_t cnt, wide_t lo, wide_t hi);
    return (cnt >= lo) && (cnt < hi);
  endfunction

  // Saturating step of a value whose top allowed value is lim.
  function automatic wide_t sat_step(wide_t v, wide_t lim);
    return (v >= lim) ? lim : v + wide_t'(1);
  endfunction
endpackage

// File: rtl/vacq_edge.sv
module vacq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level_in,
  output logic rise
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level_in;
  end

  assign rise = level_in & ~level_q;
endmodule

// File: rtl/vacq_line_counter.sv
module vacq_line_counter #(
  parameter int unsigned LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_pulse,
  input  logic              restart,
  output logic [LINE_W-1:0] line_cnt,
  output logic [LINE_W-1:0] field_len
);
  import vacq_pkg::*;
  localparam wide_t LIM = wide_t'((1 << LINE_W) - 1);

  wide_t next_cnt;
  assign next_cnt = sat_step(wide_t'(line_cnt), LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_cnt  <= '0;
      field_len <= '0;
    end else if (restart) begin
      field_len <= line_cnt;
      line_cnt  <= '0;
    end else if (line_pulse) begin
      line_cnt  <= next_cnt[LINE_W-1:0];
    end
  end
endmodule

// File: rtl/vacq_offset_meter.sv
module vacq_offset_meter #(
  parameter int unsigned OFF_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             line_pulse,
  output logic [OFF_W-1:0] sync_offset
);
  import vacq_pkg::*;
  localparam wide_t LIM = wide_t'((1 << OFF_W) - 1);

  logic             running;
  logic [OFF_W-1:0] run_cnt;
  wide_t            next_run;
  assign next_run = sat_step(wide_t'(run_cnt), LIM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running     <= 1'b0;
      run_cnt     <= '0;
      sync_offset <= '0;
    end else if (start) begin
      if (line_pulse) begin
        sync_offset <= '0;
        running     <= 1'b0;
      end else begin
        running     <= 1'b1;
        run_cnt     <= OFF_W'(1);
      end
    end else if (running) begin
      if (line_pulse) begin
        sync_offset <= run_cnt;
        running     <= 1'b0;
      end else begin
        run_cnt     <= next_run[OFF_W-1:0];
      end
    end
  end
endmodule

// File: rtl/vacq_timing.sv
module vacq_timing #(
  parameter int unsigned LINE_W = 10,
  parameter int unsigned OFF_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              vsync_in,
  input  logic              line_pulse,
  input  logic [LINE_W-1:0] win_start,
  input  logic [LINE_W-1:0] win_stop,
  output logic [LINE_W-1:0] line_cnt,
  output logic [LINE_W-1:0] field_len,
  output logic [OFF_W-1:0]  sync_offset,
  output logic              field_id,
  output logic              wr_reset,
  output logic              wr_window
);
  import vacq_pkg::*;

  logic vsync_rise;

  vacq_edge u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .level_in (vsync_in),
    .rise     (vsync_rise)
  );

  vacq_line_counter #(.LINE_W(LINE_W)) u_lines (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_pulse (line_pulse),
    .restart    (vsync_rise),
    .line_cnt   (line_cnt),
    .field_len  (field_len)
  );

  vacq_offset_meter #(.OFF_W(OFF_W)) u_offset (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (vsync_rise),
    .line_pulse  (line_pulse),
    .sync_offset (sync_offset)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          field_id <= 1'b0;
    else if (vsync_rise) field_id <= ~field_id;
  end

  assign wr_reset  = (line_cnt == '0);
  assign wr_window = in_window(wide_t'(line_cnt), wide_t'(win_start), wide_t'(win_stop));
endmodule

// File: rtl/vacq_timing_chk.sv
module vacq_timing_chk #(
  parameter int unsigned LINE_W = 10,
  parameter int unsigned OFF_W  = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              vsync_rise,
  input logic              line_pulse,
  input logic [LINE_W-1:0] win_start,
  input logic [LINE_W-1:0] win_stop,
  input logic [LINE_W-1:0] line_cnt,
  input logic [LINE_W-1:0] field_len,
  input logic [OFF_W-1:0]  sync_offset,
  input logic              field_id,
  input logic              wr_reset,
  input logic              wr_window
);
  localparam logic [LINE_W-1:0] TOP = '1;

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!vsync_rise && line_pulse && line_cnt != TOP) |=> line_cnt == $past(line_cnt) + 1'b1);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!vsync_rise && !line_pulse) |=> $stable(line_cnt));
  assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_rise |=> line_cnt == '0);
  assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_rise |=> field_len == $past(line_cnt));
  assert_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!vsync_rise && line_cnt == TOP) |=> line_cnt == TOP);
  assert_zero_offset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync_rise && line_pulse) |=> sync_offset == '0);
  assert_reset_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_reset) |-> $past(vsync_rise));
  assert_empty_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (win_start >= win_stop) |-> !wr_window);
  assert_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_rise |=> field_id != $past(field_id));
  assert_steady_id_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_rise |=> $stable(field_id));
  assert_single_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vsync_rise |=> !vsync_rise);
endmodule

bind vacq_timing vacq_timing_chk #(.LINE_W(LINE_W), .OFF_W(OFF_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .vsync_rise  (vsync_rise),
  .line_pulse  (line_pulse),
  .win_start   (win_start),
  .win_stop    (win_stop),
  .line_cnt    (line_cnt),
  .field_len   (field_len),
  .sync_offset (sync_offset),
  .field_id    (field_id),
  .wr_reset    (wr_reset),
  .wr_window   (wr_window)
);

// File: tb/test_vacq_timing.sv
module test_vacq_timing;
  localparam int CLK_PERIOD = 10;
  localparam int LINE_W = 10;
  localparam int OFF_W  = 12;
  localparam int LMAX   = (1 << LINE_W) - 1;
  localparam int NV     = 5;
  // columns: offset clocks, line pulses, gap clocks, window start, window stop
  localparam int TAB [NV][5] = '{
    '{3, 12, 4,  2,  6},
    '{0,  8, 3,  0,  3},
    '{1, 15, 2,  5,  5},
    '{7, 20, 5, 10, 30},
    '{2,  5, 6,  4,  2}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vsync_in = 1'b0;
  logic line_pulse = 1'b0;
  logic [LINE_W-1:0] win_start = '0;
  logic [LINE_W-1:0] win_stop = '0;
  logic [LINE_W-1:0] line_cnt, field_len;
  logic [OFF_W-1:0]  sync_offset;
  logic field_id, wr_reset, wr_window;

  int n_chk = 0;
  int n_bad = 0;
  int exp_len = 0;
  bit have_prev = 1'b0;
  bit exp_fid = 1'b0;
  int cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vacq_timing #(.LINE_W(LINE_W), .OFF_W(OFF_W)) i_vacq_timing (
    .clk(clk), .rst_n(rst_n), .vsync_in(vsync_in), .line_pulse(line_pulse),
    .win_start(win_start), .win_stop(win_stop), .line_cnt(line_cnt),
    .field_len(field_len), .sync_offset(sync_offset), .field_id(field_id),
    .wr_reset(wr_reset), .wr_window(wr_window)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model_cnt(int c);
    return (c > LMAX) ? LMAX : c;
  endfunction

  function automatic bit model_win(int c, int s, int e);
    return (c >= s) && (c < e);
  endfunction

  task automatic line_checks(input int k, input int s, input int e);
    int c = model_cnt(cnt);
    chk(int'(line_cnt) == c, "R2 line_cnt", int'(line_cnt), c);
    chk(wr_window == model_win(c, s, e), "R7 wr_window", int'(wr_window), int'(model_win(c, s, e)));
    chk(wr_reset == (c == 0), "R6 wr_reset", int'(wr_reset), int'(c == 0));
    chk(int'(sync_offset) == k, "R5 sync_offset", int'(sync_offset), k);
  endtask

  task automatic one_pulse();
    line_pulse = 1'b1;
    @(negedge clk);
    line_pulse = 1'b0;
    cnt++;
  endtask

  // Sync edge, then n line pulses: the first k clocks after the edge, the rest gap apart.
  task automatic run_field(input int k, input int n, input int gap, input int s, input int e);
    @(negedge clk);
    win_start = LINE_W'(s);
    win_stop  = LINE_W'(e);
    vsync_in = 1'b1;
    line_pulse = (k == 0);
    @(negedge clk);
    vsync_in = 1'b0;
    line_pulse = 1'b0;
    exp_fid = ~exp_fid;
    if (have_prev)
      chk(int'(field_len) == exp_len, "R3 field_len", int'(field_len), exp_len);
    chk(field_id == exp_fid, "R8 field_id", int'(field_id), int'(exp_fid));
    cnt = 0;
    if (k == 0) begin
      // R3: coincident line pulse is dropped; R5: offset reads 0
      chk(int'(sync_offset) == 0, "R5 coincident offset", int'(sync_offset), 0);
      line_checks(0, s, e);
    end else begin
      chk(wr_reset == 1'b1, "R6 wr_reset after edge", int'(wr_reset), 1);
      repeat (k-1) @(negedge clk);
      one_pulse();
      line_checks(k, s, e);
    end
    for (int j = 1; j < n; j++) begin
      repeat (gap-1) @(negedge clk);
      one_pulse();
      line_checks(k, s, e);
    end
    exp_len = model_cnt(cnt);
    have_prev = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    win_start = LINE_W'(2);
    win_stop  = LINE_W'(5);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(line_cnt == '0, "R1 line_cnt", int'(line_cnt), 0);
    chk(field_len == '0, "R1 field_len", int'(field_len), 0);
    chk(sync_offset == '0, "R1 sync_offset", int'(sync_offset), 0);
    chk(field_id == 1'b0, "R1 field_id", int'(field_id), 0);
    chk(wr_reset == 1'b1, "R1 wr_reset", int'(wr_reset), 1);
    chk(wr_window == 1'b0, "R1 wr_window", int'(wr_window), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++)
      run_field(TAB[v][0], TAB[v][1], TAB[v][2], TAB[v][3], TAB[v][4]);

    // R9: long sync, line pulses during it are counted, one toggle only
    @(negedge clk);
    vsync_in = 1'b1;
    @(negedge clk);
    exp_fid = ~exp_fid;
    chk(int'(field_len) == exp_len, "R3 field_len last vector", int'(field_len), exp_len);
    cnt = 0;
    repeat (3) begin
      @(negedge clk);
      one_pulse();
    end
    chk(int'(line_cnt) == 3, "R9 lines during long sync", int'(line_cnt), 3);
    chk(field_id == exp_fid, "R9 single toggle", int'(field_id), int'(exp_fid));
    chk(int'(sync_offset) == 2, "R9 offset during long sync", int'(sync_offset), 2);
    vsync_in = 1'b0;
    exp_len = 3;

    // R4: saturation over a long field
    run_field(1, LMAX + 8, 1, 0, 0);
    chk(int'(line_cnt) == LMAX, "R4 saturated line_cnt", int'(line_cnt), LMAX);
    run_field(4, 2, 3, 0, 1);
    chk(int'(field_len) == LMAX, "R4 saturated field_len", int'(field_len), LMAX);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule